// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetch Engine

This block serves a transmit queue whose descriptors sit in host memory as a ring. Each descriptor takes 16 bytes and holds four 32-bit words: a control word at offset 0, a tag word at offset 4, the low half of the buffer address at offset 8 and the high half at offset 12. Software fills descriptors, sets their ownership bit and then writes the poll register. The engine then walks the ring through a simple synchronous memory port. For every owned descriptor it hands the buffer address and the frame length to a downstream sender. When the sender reports completion, the engine writes the control word back with ownership cleared.

The ring has no fixed length. A descriptor flagged as ring end sends the engine back to the base address. A scan stops at the first descriptor that software has not handed over. At that point the engine raises a descriptor-unavailable flag and waits for the next poll. Completion and error are reported as one-cycle pulses in a 16-bit status word.

Top module: `tx_ring_fetch`

## Requirements
- R1: While reset is held and after it is released, with no poll, `mem_req`, `tx_valid` and `int_flags` are all zero.
- R2: A poll write with `poll_data` bit 6 set starts a scan. A poll write with bit 6 clear is ignored, and no memory request follows it.
- R3: For an owned descriptor, the engine reads the control word (offset 0) and the address words (offsets 8 and 12). It never reads the tag word (offset 4). It presents `tx_addr` = {word12, word8} and `tx_len` = control[15:0] with `tx_valid`, and holds both stable until `tx_ready`.
- R4: After `tx_done`, the engine writes the control word back to the same address with bit 31 (owner) cleared and every other bit unchanged. It pulses `int_flags` bit 2 (transmit OK) in the write cycle.
- R5: An owned descriptor that lacks control bit 29 (first segment) or bit 28 (last segment) is never offered to the sender. It is written back with bit 31 cleared, and `int_flags` bit 3 (transmit error) pulses.
- R6: A control word read with bit 31 clear pulses `int_flags` bit 7 (descriptor unavailable). The engine makes no write and goes idle at the same descriptor, and the next poll reads that descriptor again.
- R7: After a descriptor with control bit 30 (ring end) is handled, the next descriptor is read at the ring base. Otherwise it is read 16 bytes further on.
- R8: A poll write that arrives during a scan is remembered. Once the scan ends, another scan runs without any further poll.
- R9: Bits 7:0 of `ring_base` are ignored, so the ring is always 256-byte aligned.
- R10: The ring offset is `OFF_W` bits wide. Without a ring-end mark, the walk wraps to the base after 2^OFF_W bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | 64 | Ring base byte address |
| poll_wr | input | 1 | Poll register write strobe |
| poll_data | input | 8 | Poll register write data (bit 6 = scan) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| tx_valid | output | 1 | Frame offer to sender |
| tx_ready | input | 1 | Sender accepts the offer |
| tx_addr | output | 64 | Frame buffer address |
| tx_len | output | 16 | Frame length in bytes |
| tx_done | input | 1 | Sender finished the frame |
| int_flags | output | 16 | Status pulses: bit 2 OK, bit 3 error, bit 7 unavailable |

## Verification
The bench builds the engine with `OFF_W` = 8, which gives a 256-byte ring of 16 descriptors. A run of 16 owned descriptors without a ring-end mark therefore shows the offset wrap, and a marker descriptor placed just past the ring proves that the engine never reaches it. The sender model holds `tx_ready` low on demand. This exposes the hold behaviour and gives a window in which a second poll lands mid-scan.

// File: rtl/tx_ring_fetch.sv
module tx_ring_fetch #(
  parameter int OFF_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] ring_base,
  input  logic        poll_wr,
  input  logic [7:0]  poll_data,
  output logic        mem_req,
  output logic        mem_we,
  output logic [63:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [63:0] tx_addr,
  output logic [15:0] tx_len,
  input  logic        tx_done,
  output logic [15:0] int_flags
);
  localparam int STEP = 16;
  localparam int OK_BIT = 2;
  localparam int ERR_BIT = 3;
  localparam int NODESC_BIT = 7;

  typedef enum logic [2:0] {IDLE, RCTL, CHK, RLO, RHI, SEND, WAIT, WB} st_t;

  st_t              st;
  logic [OFF_W-1:0] off;
  logic [31:0]      ctrl, alo, ahi;
  logic             pend, err;

  wire        own      = mem_rdata[31];
  wire        whole    = mem_rdata[29] & mem_rdata[28];
  wire [63:0] desc_at  = {ring_base[63:8], 8'h00} + {{(64-OFF_W){1'b0}}, off};

  assign mem_req   = (st == RCTL) || (st == CHK && own && whole) || (st == RLO) || (st == WB);
  assign mem_we    = (st == WB);
  assign mem_addr  = desc_at + ((st == CHK) ? 64'd8 : (st == RLO) ? 64'd12 : 64'd0);
  assign mem_wdata = {1'b0, ctrl[30:0]};
  assign tx_valid  = (st == SEND);
  assign tx_addr   = {ahi, alo};
  assign tx_len    = ctrl[15:0];

  always_comb begin
    int_flags = '0;
    int_flags[OK_BIT]     = (st == WB) && !err;
    int_flags[ERR_BIT]    = (st == WB) && err;
    int_flags[NODESC_BIT] = (st == CHK) && !own;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= IDLE;
      off  <= '0;
      ctrl <= '0;
      alo  <= '0;
      ahi  <= '0;
      pend <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (st == IDLE && pend) pend <= 1'b0;
      if (poll_wr && poll_data[6]) pend <= 1'b1;
      case (st)
        IDLE: if (pend) st <= RCTL;
        RCTL: st <= CHK;
        CHK: begin
          ctrl <= mem_rdata;
          err  <= !whole;
          if (!own)       st <= IDLE;
          else if (whole) st <= RLO;
          else            st <= WB;
        end
        RLO: begin alo <= mem_rdata; st <= RHI; end
        RHI: begin ahi <= mem_rdata; st <= SEND; end
        SEND: if (tx_ready) st <= WAIT;
        WAIT: if (tx_done) st <= WB;
        WB: begin
          off <= ctrl[30] ? '0 : off + OFF_W'(STEP);
          st  <= RCTL;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module tx_ring_fetch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_wdata,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [63:0] tx_addr,
  input logic [15:0] tx_len,
  input logic [15:0] int_flags
);
  // R3
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_addr) && $stable(tx_len));
  // R3
  no_mem_while_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !mem_req);
  // R4
  release_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[31]);
  // R4
  ok_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_flags[2] |-> mem_req && mem_we);
  // R5
  err_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_flags[3] |-> mem_req && mem_we && !tx_valid);
  // R6
  nodesc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_flags[7] |-> !mem_we ##1 !mem_req);
  // R1
  flags_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(int_flags));
endmodule

bind tx_ring_fetch tx_ring_fetch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_wdata(mem_wdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_addr(tx_addr), .tx_len(tx_len), .int_flags(int_flags));

// File: tb/tx_ring_fetch_bench.sv
module tx_ring_fetch_bench;
  localparam int OFF_W = 8;
  localparam logic [31:0] OWN = 32'h8000_0000, EOR = 32'h4000_0000,
                          FS = 32'h2000_0000, LS = 32'h1000_0000;

  logic clk = 0, rst_n = 0;
  logic [63:0] ring_base = 64'h200;
  logic poll_wr = 0;
  logic [7:0] poll_data = 0;
  logic mem_req, mem_we;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic tx_valid, ready_en = 1, tx_done = 0;
  logic [63:0] tx_addr;
  logic [15:0] tx_len, int_flags;

  always #2.5 clk = ~clk;

  tx_ring_fetch #(.OFF_W(OFF_W)) u_tx_ring_fetch (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .poll_wr(poll_wr),
    .poll_data(poll_data), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(ready_en), .tx_addr(tx_addr),
    .tx_len(tx_len), .tx_done(tx_done), .int_flags(int_flags));

  logic [31:0] mem [0:1023];
  logic [63:0] cap_addr [0:31];
  logic [15:0] cap_len [0:31];
  int n_send = 0, n_ok = 0, n_err = 0, n_tdu = 0, n_req = 0, n_tag = 0;
  int dcnt = 0;
  int compared = 0, mismatched = 0;

  always @(posedge clk) begin
    tx_done <= 1'b0;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[11:2]];
    if (mem_req && mem_we) mem[mem_addr[11:2]] <= mem_wdata;
    if (rst_n) begin
      if (mem_req) n_req <= n_req + 1;
      if (mem_req && !mem_we && mem_addr[3:0] == 4'h4) n_tag <= n_tag + 1;
      if (int_flags[2]) n_ok <= n_ok + 1;
      if (int_flags[3]) n_err <= n_err + 1;
      if (int_flags[7]) n_tdu <= n_tdu + 1;
      if (tx_valid && ready_en) begin
        cap_addr[n_send % 32] <= tx_addr;
        cap_len[n_send % 32] <= tx_len;
        n_send <= n_send + 1;
        dcnt <= 3;
      end else if (dcnt != 0) begin
        dcnt <= dcnt - 1;
        if (dcnt == 1) tx_done <= 1'b1;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
  endtask

  task automatic put_desc(input logic [63:0] a, input logic [31:0] c, input logic [63:0] buf_a);
    mem[a[11:2]]     = c;
    mem[a[11:2] + 1] = 32'h0000_ABCD;
    mem[a[11:2] + 2] = buf_a[31:0];
    mem[a[11:2] + 3] = buf_a[63:32];
  endtask

  task automatic do_reset(input logic [63:0] base);
    @(negedge clk);
    rst_n = 0; ring_base = base; ready_en = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic poll(input logic [7:0] d);
    @(negedge clk);
    poll_wr = 1; poll_data = d;
    @(negedge clk);
    poll_wr = 0; poll_data = 0;
  endtask

  task automatic wait_tdu(input int target, input string req);
    int t = 0;
    while (n_tdu < target && t < 3000) begin @(negedge clk); t++; end
    if (n_tdu < target) chk(req, 64'(n_tdu), 64'(target));
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R1 req in reset", {63'd0, mem_req}, 0);
    chk("R1 flags in reset", {48'd0, int_flags}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R1 valid after reset", {63'd0, tx_valid}, 0);
    chk("R1 no request after reset", 64'(n_req), 0);
  endtask

  task automatic t_ignored_poll();
    int r0 = n_req;
    poll(8'hBF);
    repeat (10) @(negedge clk);
    chk("R2 poll without bit6 ignored", 64'(n_req - r0), 0);
  endtask

  task automatic t_single();
    int s0, o0, g0, d0;
    clear_mem();
    do_reset(64'h25A);
    s0 = n_send; o0 = n_ok; g0 = n_tag; d0 = n_tdu;
    put_desc(64'h200, OWN | FS | LS | 32'h05EA, 64'h1_DEAD_0000);
    poll(8'h40);
    wait_tdu(d0 + 1, "R2 scan ends");
    chk("R3 one frame", 64'(n_send - s0), 1);
    chk("R3 addr R9 base low bits ignored", cap_addr[s0 % 32], 64'h1_DEAD_0000);
    chk("R3 len", 64'(cap_len[s0 % 32]), 64'h5EA);
    chk("R3 tag word unread", 64'(n_tag - g0), 0);
    chk("R4 writeback", 64'(mem[64'h200 >> 2]), 64'(FS | LS | 32'h05EA));
    chk("R4 ok pulse", 64'(n_ok - o0), 1);
    chk("R6 next slot untouched", 64'(mem[64'h210 >> 2]), 0);
  endtask

  task automatic t_eor();
    int s0, o0, d0;
    clear_mem();
    do_reset(64'h400);
    s0 = n_send; o0 = n_ok; d0 = n_tdu;
    put_desc(64'h400, OWN | FS | LS | 32'd60, 64'h1000);
    put_desc(64'h410, OWN | FS | LS | 32'd61, 64'h2000);
    put_desc(64'h420, OWN | EOR | FS | LS | 32'd62, 64'h3000);
    put_desc(64'h430, OWN | FS | LS | 32'd63, 64'h4000);
    poll(8'h40);
    wait_tdu(d0 + 1, "R7 scan ends");
    chk("R7 three frames", 64'(n_send - s0), 3);
    chk("R7 order", cap_addr[(s0 + 2) % 32], 64'h3000);
    chk("R4 end mark kept", 64'(mem[64'h420 >> 2]), 64'(EOR | FS | LS | 32'd62));
    chk("R7 beyond end untouched", 64'(mem[64'h430 >> 2]), 64'(OWN | FS | LS | 32'd63));
    mem[64'h400 >> 2] = OWN | FS | LS | 32'd77;
    poll(8'h40);
    wait_tdu(d0 + 2, "R6 rescan ends");
    chk("R6 R7 rescan at base", cap_addr[(s0 + 3) % 32], 64'h1000);
    chk("R6 rescan len", 64'(cap_len[(s0 + 3) % 32]), 77);
    chk("R4 ok count", 64'(n_ok - o0), 4);
  endtask

  task automatic t_error();
    int s0, e0, d0;
    clear_mem();
    do_reset(64'h600);
    s0 = n_send; e0 = n_err; d0 = n_tdu;
    put_desc(64'h600, OWN | FS | 32'd100, 64'h5000);
    put_desc(64'h610, OWN | LS | 32'd101, 64'h6000);
    poll(8'h40);
    wait_tdu(d0 + 1, "R5 scan ends");
    chk("R5 nothing sent", 64'(n_send - s0), 0);
    chk("R5 error pulses", 64'(n_err - e0), 2);
    chk("R5 writeback first", 64'(mem[64'h600 >> 2]), 64'(FS | 32'd100));
    chk("R5 writeback second", 64'(mem[64'h610 >> 2]), 64'(LS | 32'd101));
  endtask

  task automatic t_backpressure_and_latch();
    int o0, d0, t;
    logic [63:0] a0;
    clear_mem();
    do_reset(64'h200);
    o0 = n_ok; d0 = n_tdu;
    put_desc(64'h200, OWN | FS | LS | 32'd1500, 64'hAB_0000_1230);
    ready_en = 0;
    poll(8'h40);
    t = 0;
    while (!tx_valid && t < 100) begin @(negedge clk); t++; end
    a0 = tx_addr;
    poll(8'h40);
    repeat (4) @(negedge clk);
    chk("R3 valid held", {63'd0, tx_valid}, 1);
    chk("R3 addr stable", tx_addr, a0);
    chk("R3 addr value", a0, 64'hAB_0000_1230);
    ready_en = 1;
    wait_tdu(d0 + 1, "R8 first scan ends");
    repeat (40) @(negedge clk);
    chk("R8 latched poll rescans", 64'(n_tdu - d0), 2);
    chk("R8 one frame only", 64'(n_ok - o0), 1);
  endtask

  task automatic t_wrap();
    int o0, d0;
    clear_mem();
    do_reset(64'h800);
    o0 = n_ok; d0 = n_tdu;
    for (int i = 0; i < 16; i++)
      put_desc(64'h800 + 64'(i * 16), OWN | FS | LS | 32'(i + 1), 64'(i));
    put_desc(64'h900, OWN | FS | LS | 32'd999, 64'h9999);
    poll(8'h40);
    wait_tdu(d0 + 1, "R10 scan ends");
    chk("R10 sixteen frames", 64'(n_ok - o0), 16);
    chk("R10 past ring untouched", 64'(mem[64'h900 >> 2]), 64'(OWN | FS | LS | 32'd999));
  endtask

  initial begin
    clear_mem();
    t_reset();
    t_ignored_poll();
    t_single();
    t_eor();
    t_error();
    t_backpressure_and_latch();
    t_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule